// File: doc/BRIEF.md
# Dual-Channel DAC Data Register Write Port

This block is the digital front end of a two-channel, 8-bit digital-to-analog converter. A host drives one shared 8-bit data bus, an active-low chip select, an active-low write strobe and a channel-select line. The block keeps one data register per channel. A write completes when the window in which chip select and write strobe are both low closes, whichever of the two strobes rises first. It then presents both register contents as the output codes. The strobes and the reset come from outside the system clock domain. They pass through two-flop synchronizers, and all edge detection happens in the clock domain.

The channel and the data word are taken when the low window opens. The register itself only changes when the window closes, so a strobe held low never lets bus activity through to the output. An active-low reset clears both registers at once and has priority over any write. The block also reports, per channel, whether the output sits at its rest level. With a unipolar range that level is the zero-volt point. With a bipolar range it is negative full scale. Each channel gives a one-cycle update pulse when its register is loaded, and both channels pulse once when reset ends.

Top module: `dual_dac_wrif`

## Requirements
- R1: While `rst_n` is low, both `code_a` and `code_b` read 0 and no update pulse occurs, whatever the strobes do. The clear takes effect without waiting for a clock edge.
- R2: After `rst_n` rises, `update_a` and `update_b` are both high for exactly one cycle, following the third rising clock edge after the release.
- R3: `ch_sel` = 0 routes a write to channel A (`code_a`, `update_a`), and `ch_sel` = 1 routes it to channel B (`code_b`, `update_b`). The other channel's code does not change and its update stays low.
- R4: A rising edge on `wr_n` while `cs_n` is low loads the register.
- R5: A rising edge on `cs_n` while `wr_n` is low loads the register. If both strobes rise together, exactly one load occurs.
- R6: While `cs_n` and `wr_n` are both low, neither code changes, however long the low window lasts (no transparency).
- R7: `ch_sel` and `din` are taken at the third rising clock edge after both strobes are low. Changes to them later in the same window do not affect the write. Every strobe level must be held for at least three clock cycles.
- R8: While `cs_n` is high, activity on `wr_n` changes neither code and raises no update pulse.
- R9: The new code appears, together with a one-cycle update pulse, after the third rising clock edge that follows the qualifying strobe rise. After the second such edge, the old code is still shown.
- R10: `at_zero_v[i]` is 1 exactly when the channel's code is 0 and `bipolar` is 0. `at_neg_fs[i]` is 1 exactly when the code is 0 and `bipolar` is 1. Bit 0 is channel A and bit 1 is channel B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears both registers asynchronously |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| ch_sel | input | 1 | Channel select: 0 = A, 1 = B |
| din | input | 8 | Shared data bus |
| bipolar | input | 1 | Output range: 0 = unipolar, 1 = bipolar (static) |
| code_a | output | 8 | Channel A register contents |
| code_b | output | 8 | Channel B register contents |
| update_a | output | 1 | One-cycle pulse on a channel A load or at reset end |
| update_b | output | 1 | One-cycle pulse on a channel B load or at reset end |
| at_zero_v | output | 2 | Per channel: output at zero volts (unipolar rest) |
| at_neg_fs | output | 2 | Per channel: output at negative full scale (bipolar rest) |

## Verification
Every path from an input passes through three registers: the two synchronizer flops, then either the window flop or the data register. A written code and its update pulse are therefore due after the third rising edge that follows the strobe rise. The end-of-reset pulse is due after the third rising edge that follows the release. The bench changes inputs on falling edges and counts rising edges from that point. It checks that the old value is still shown one edge early, that the new value and the pulse appear on time, and that the pulse is gone one cycle later. The reset clear is checked a moment after `rst_n` falls, without waiting for an edge. The rest flags are combinational and are read together with the codes.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

  // Rest-level flags for a channel: {negative full scale, zero volts}
  function automatic logic [1:0] floor_flags(input logic is_zero, input logic bip);
    return {is_zero & bip, is_zero & ~bip};
  endfunction

  // Does a captured select value address channel idx
  function automatic logic picks(input int unsigned sel, input int unsigned idx);
    return sel == idx;
  endfunction

endpackage

// File: rtl/dacw_rst_sync.sv
module dacw_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stg;

  // Asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stg <= 2'b00;
    else         stg <= {stg[0], 1'b1};
  end

  assign rst_no = stg[1];
endmodule

// File: rtl/dacw_sync.sv
module dacw_sync #(
  parameter int unsigned W       = 2,
  parameter bit          RST_ONE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] RST_VAL = {W{RST_ONE}};

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[b];
        s2 <= RST_VAL[b];
      end else begin
        s1 <= d_i[b];
        s2 <= s1;
      end
    end
    assign q_o[b] = s2;
  end
endmodule

// File: rtl/dacw_window.sv
module dacw_window #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cs_s,
  input  logic              wr_s,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              win_o,
  output logic              load_o,
  output logic [SEL_W-1:0]  sel_q,
  output logic [DATA_W-1:0] dat_q
);
  logic both_now, both_q, opening;

  assign both_now = ~cs_s & ~wr_s;
  assign opening  = both_now & ~both_q;
  // Either strobe rising closes the window: one load, whichever rose
  assign load_o   = both_q & ~both_now;
  assign win_o    = both_now;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      both_q <= 1'b0;
      sel_q  <= '0;
      dat_q  <= '0;
    end else begin
      both_q <= both_now;
      if (opening) begin
        sel_q <= sel_i;
        dat_q <= din_i;
      end
    end
  end

  // R7
  sel_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (both_now && both_q) |=> ($stable(sel_q) && $stable(dat_q)));

  // R5
  load_once_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/dacw_chreg.sv
module dacw_chreg
  import dacw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 1,
  parameter int unsigned IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              fresh_i,
  input  logic              win_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] code_o,
  output logic              upd_o
);
  assign hit_o = load_i & picks(32'(sel_i), IDX);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= hit_o | fresh_i;
      if (hit_o) code_o <= dat_i;
    end
  end

  // R6
  no_transparency_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    win_i |=> $stable(code_o));

  // R9
  code_change_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (code_o != $past(code_o)) |-> upd_o);

  // R9
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    upd_o |=> !upd_o);
endmodule

// File: rtl/dual_dac_wrif.sv
module dual_dac_wrif
  import dacw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ch_sel,
  input  logic [DATA_W-1:0] din,
  input  logic              bipolar,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              update_a,
  output logic              update_b,
  output logic [1:0]        at_zero_v,
  output logic [1:0]        at_neg_fs
);
  localparam int unsigned NCH   = 2;
  localparam int unsigned SEL_W = $clog2(NCH);

  logic              rst_s_n;
  logic [1:0]        strb_s;
  logic              win, load;
  logic [SEL_W-1:0]  sel_cap;
  logic [DATA_W-1:0] dat_cap;
  logic              fresh;
  logic [NCH-1:0]    hit, upd;
  logic [DATA_W-1:0] code [NCH];

  dacw_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_s_n));

  dacw_sync #(.W(2), .RST_ONE(1'b1)) u_strb (
    .clk(clk), .rst_ni(rst_s_n), .d_i({cs_n, wr_n}), .q_o(strb_s)
  );

  dacw_window #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_win (
    .clk(clk), .rst_ni(rst_s_n), .cs_s(strb_s[1]), .wr_s(strb_s[0]),
    .sel_i(ch_sel), .din_i(din), .win_o(win), .load_o(load),
    .sel_q(sel_cap), .dat_q(dat_cap)
  );

  // High for the first cycle out of reset; drives the reset-end pulses
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) fresh <= 1'b1;
    else          fresh <= 1'b0;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dacw_chreg #(.DATA_W(DATA_W), .SEL_W(SEL_W), .IDX(g)) u_reg (
      .clk(clk), .rst_ni(rst_s_n), .load_i(load), .sel_i(sel_cap),
      .dat_i(dat_cap), .fresh_i(fresh), .win_i(win),
      .hit_o(hit[g]), .code_o(code[g]), .upd_o(upd[g])
    );
    assign {at_neg_fs[g], at_zero_v[g]} = floor_flags(code[g] == '0, bipolar);
  end

  assign code_a   = code[0];
  assign code_b   = code[1];
  assign update_a = upd[0];
  assign update_b = upd[1];

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(hit));

  // R2
  fresh_both_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    fresh |=> (update_a && update_b));
endmodule

// File: tb/dual_dac_wrif_test.sv
module dual_dac_wrif_test;
  logic       clk = 1'b0;
  logic       rst_n, cs_n, wr_n, ch_sel, bipolar;
  logic [7:0] din;
  logic [7:0] code_a, code_b;
  logic       update_a, update_b;
  logic [1:0] at_zero_v, at_neg_fs;

  int nchk = 0, nerr = 0;
  int cnt_a = 0, cnt_b = 0;
  logic [7:0] ea = 8'h00, eb = 8'h00;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_dac_wrif uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ch_sel(ch_sel),
    .din(din), .bipolar(bipolar), .code_a(code_a), .code_b(code_b),
    .update_a(update_a), .update_b(update_b),
    .at_zero_v(at_zero_v), .at_neg_fs(at_neg_fs)
  );

  always @(negedge clk) begin
    if (update_a) cnt_a++;
    if (update_b) cnt_b++;
  end

  function automatic logic [1:0] exp_zero(logic [7:0] a, logic [7:0] b, logic bip);
    return {(b == 8'h00) && !bip, (a == 8'h00) && !bip};
  endfunction

  function automatic logic [1:0] exp_neg(logic [7:0] a, logic [7:0] b, logic bip);
    return {(b == 8'h00) && bip, (a == 8'h00) && bip};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_codes(string req);
    chk({req, " code_a"}, 32'(code_a), 32'(ea));
    chk({req, " code_b"}, 32'(code_b), 32'(eb));
    chk("R10 at_zero_v", 32'(at_zero_v), 32'(exp_zero(ea, eb, bipolar)));
    chk("R10 at_neg_fs", 32'(at_neg_fs), 32'(exp_neg(ea, eb, bipolar)));
  endtask

  // mode 0: wr_n rises with cs_n low; 1: cs_n rises with wr_n low; 2: both rise
  task automatic do_write(int mode, logic s, logic [7:0] d, int hold, bit flip);
    @(negedge clk);
    ch_sel = s; din = d;
    if (mode == 0) begin cs_n = 1'b0; @(negedge clk); wr_n = 1'b0; end
    else if (mode == 1) begin wr_n = 1'b0; @(negedge clk); cs_n = 1'b0; end
    else begin cs_n = 1'b0; wr_n = 1'b0; end
    repeat (hold) @(negedge clk);
    chk_codes("R6 window open");
    if (flip) begin
      ch_sel = ~s; din = ~d;
      repeat (3) @(negedge clk);
      chk_codes("R6 window long");
    end
    if (mode == 0) wr_n = 1'b1;
    else if (mode == 1) cs_n = 1'b1;
    else begin cs_n = 1'b1; wr_n = 1'b1; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_codes("R9 old code edge two");
    chk("R9 no early update", {update_b, update_a}, 0);
    if (s) eb = d; else ea = d;
    @(negedge clk);
    chk_codes(mode == 0 ? "R4 wr edge load" : (mode == 1 ? "R5 cs edge load" : "R5 joint load"));
    chk(flip ? "R7 redirect ignored" : "R3 update route", {update_b, update_a}, s ? 2 : 1);
    // the second strobe rises now, with the other high: no load
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk("R9 pulse one cycle", {update_b, update_a}, 0);
    repeat (4) @(negedge clk);
    chk_codes("R5 trailing strobe no load");
  endtask

  task automatic reset_release_check(string req);
    rst_n = 1'b1;
    @(negedge clk); chk({req, " edge1"}, {update_b, update_a}, 0);
    @(negedge clk); chk({req, " edge2"}, {update_b, update_a}, 0);
    @(negedge clk); chk({req, " edge3"}, {update_b, update_a}, 3);
    @(negedge clk); chk({req, " edge4"}, {update_b, update_a}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int ca, cb;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ch_sel = 1'b0; din = 8'h00; bipolar = 1'b0;
    repeat (3) @(negedge clk);
    chk_codes("R1 reset state");
    // R1: strobe activity during reset is overridden
    din = 8'h5A; cs_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_codes("R1 write during reset");
    chk("R1 no update in reset", {update_b, update_a}, 0);
    reset_release_check("R2 reset end pulse");

    // directed writes
    do_write(0, 1'b0, 8'hA5, 4, 1'b0);
    do_write(1, 1'b1, 8'h3C, 4, 1'b0);
    do_write(2, 1'b0, 8'hFF, 3, 1'b0);
    do_write(0, 1'b1, 8'h01, 8, 1'b1);   // R7 select/data change mid-window
    do_write(1, 1'b0, 8'h00, 4, 1'b1);   // R7 with cs-edge form, zero code
    bipolar = 1'b1;
    @(negedge clk); chk_codes("R10 bipolar rest flag");
    bipolar = 1'b0;
    @(negedge clk); chk_codes("R10 unipolar rest flag");

    // R8: cs_n high, wr_n toggles
    ca = cnt_a; cb = cnt_b;
    ch_sel = 1'b1; din = 8'h77;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); wr_n = 1'b0;
      repeat (4) @(negedge clk); wr_n = 1'b1;
      repeat (4) @(negedge clk);
    end
    chk_codes("R8 cs high wr toggles");
    chk("R8 no update A", 32'(cnt_a - ca), 0);
    chk("R8 no update B", 32'(cnt_b - cb), 0);

    // R1: reset in the middle of an open window, strobes rise during reset
    do_write(0, 1'b1, 8'h9E, 4, 1'b0);
    @(negedge clk); ch_sel = 1'b0; din = 8'h42; cs_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 ea = 8'h00; eb = 8'h00;
    chk_codes("R1 async clear");
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_codes("R1 reset overrides write");
    reset_release_check("R2 second reset end");
    repeat (4) @(negedge clk);
    chk_codes("R1 codes stay zero");

    // constrained random writes
    for (int i = 0; i < 60; i++) begin
      int m, h;
      logic s;
      logic [7:0] d;
      m = int'($urandom_range(2, 0));
      h = int'($urandom_range(7, 3));
      s = 1'($urandom_range(1, 0));
      d = 8'($urandom_range(255, 0));
      if ($urandom_range(7, 0) == 0) d = 8'h00;
      bipolar = 1'($urandom_range(1, 0));
      do_write(m, s, d, h, ($urandom_range(3, 0) == 0));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule